// File: doc/BRIEF.md
# Vectored Interrupt Data Peripheral

This block sits on a simple processor bus and moves bytes between an external producer and the processor. When the producer hands over a byte, the block stores it in an input register and raises an interrupt request. The processor answers with an acknowledge strobe. The block then places its own service-routine address (the vector) on the read data bus. The service routine reads the input register, and that read drops the request. The routine can also write a result to an output register, and the block presents that register on a parallel output port.

A control register holds a mask bit. The mask holds the interrupt line low but keeps any pending request. The control register also holds a sticky overrun flag, set when a new byte replaces one that was never read. The read data path models a three-state bus driver: a data value plus a drive enable. All outputs are registered, so a read or an acknowledge presented at one clock edge shows on the bus after that edge.

Top module: `vec_irq_periph`

## Requirements
- R1: After synchronous reset, `int_req`, `bus_oe` and `out_port` are 0, and the control register reads 0.
- R2: A cycle with `in_valid` high stores `in_data` in the input register (address 0x8000). Unless masked, `int_req` is 1 after that edge.
- R3: A read of 0x8000 returns the stored byte with `bus_oe` high after the edge. It clears the pending request, so `int_req` is 0 after the same edge.
- R4: While `int_ack` is high at an edge, the next cycle shows `bus_rdata` equal to parameter VECTOR (default 16) and `bus_oe` high. The acknowledge leaves `int_req` unchanged.
- R5: When `int_ack` and a bus read arrive in the same cycle, the vector is driven and the read is ignored, so a pending request stays pending.
- R6: A write to 0x8001 updates `out_port` after the edge, and a read of 0x8001 returns the same value.
- R7: Control register 0x8002 has bit0 = mask, bit1 = overrun and bit2 = pending. With mask set, `int_req` stays 0 but pending is kept. Clearing the mask raises `int_req` again after that write's edge.
- R8: A new `in_valid` while a request is pending and not being read overwrites the byte and sets overrun. A control write with bit1 = 1 clears overrun. Reading the input register does not clear it.
- R9: When `in_valid` and a read of 0x8000 arrive in the same cycle, the read returns the old byte, the new byte becomes pending, and overrun is not set.
- R10: Writes to 0x8000 or to unmapped addresses change no state. Reads of unmapped addresses leave `bus_oe` low.
- R11: `bus_oe` is high only in the cycle after a read of a mapped address or an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| in_valid | input | 1 | New input byte present |
| in_data | input | DATA_W | Input byte from the producer |
| int_req | output | 1 | Interrupt request |
| bus_rdata | output | DATA_W | Read data / vector driven to the bus |
| bus_oe | output | 1 | Drive enable for `bus_rdata` |
| out_port | output | DATA_W | Output register contents |

## Verification
The collisions are the hard cases to reach from the ports, because each needs two strobes in the same cycle. One is a new byte arriving in the cycle that the service routine reads the old one. The other is an acknowledge arriving together with a read. The bench times `in_valid` against the read of 0x8000, and `int_ack` against `bus_rd`, in a single cycle. It then reads the control register to see whether pending and overrun came out as R5 and R9 require. The masked case is reached the same way: mask first, then deliver a byte, then read the status before unmasking.

// File: rtl/vip_pkg.sv
package vip_pkg;
  typedef struct packed {
    logic rd_in;
    logic rd_out;
    logic rd_ctl;
    logic wr_out;
    logic wr_ctl;
  } vip_strobe_t;

  localparam int CTL_MASK_BIT = 0;
  localparam int CTL_OVR_BIT  = 1;
  localparam int CTL_PEND_BIT = 2;
endpackage

// File: rtl/vip_decode.sv
module vip_decode
  import vip_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              ack,
  output vip_strobe_t       stb
);
  localparam logic [ADDR_W-1:0] A_IN  = BASE;
  localparam logic [ADDR_W-1:0] A_OUT = BASE + 1;
  localparam logic [ADDR_W-1:0] A_CTL = BASE + 2;

  logic rd_ok;
  assign rd_ok = rd & ~ack;   // acknowledge owns the bus

  always_comb begin
    stb.rd_in  = rd_ok && (addr == A_IN);
    stb.rd_out = rd_ok && (addr == A_OUT);
    stb.rd_ctl = rd_ok && (addr == A_CTL);
    stb.wr_out = wr && (addr == A_OUT);
    stb.wr_ctl = wr && (addr == A_CTL);
  end
endmodule

// File: rtl/vip_irq_ctl.sv
module vip_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic rd_in,
  input  logic wr_ctl,
  input  logic wmask,
  input  logic wovr_clr,
  output logic pending,
  output logic mask,
  output logic overrun,
  output logic int_req
);
  logic pend_n, mask_n;

  always_comb begin
    pend_n = (pending & ~rd_in) | in_valid;
    mask_n = wr_ctl ? wmask : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      mask    <= 1'b0;
      overrun <= 1'b0;
      int_req <= 1'b0;
    end else begin
      pending <= pend_n;
      mask    <= mask_n;
      int_req <= pend_n & ~mask_n;
      if (in_valid && pending && !rd_in) overrun <= 1'b1;
      else if (wr_ctl && wovr_clr)       overrun <= 1'b0;
    end
  end

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    mask |-> !int_req);
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_in && !in_valid) |=> !pending);
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pending && !rd_in) |=> overrun);
  assert_no_false_ovr_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_in && !overrun && !(wr_ctl && !wovr_clr && 1'b0)) |=> !overrun);
endmodule

// File: rtl/vip_data_regs.sv
module vip_data_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              wr_out,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] in_reg,
  output logic [DATA_W-1:0] out_reg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg  <= '0;
      out_reg <= '0;
    end else begin
      if (in_valid) in_reg  <= in_data;
      if (wr_out)   out_reg <= wdata;
    end
  end

  assert_out_update_R6: assert property (@(posedge clk) disable iff (rst)
    wr_out |=> out_reg == $past(wdata));
  assert_in_capture_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> in_reg == $past(in_data));
endmodule

// File: rtl/vip_rd_drive.sv
module vip_rd_drive
  import vip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] VECTOR = 8'd16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  vip_strobe_t       stb,
  input  logic [DATA_W-1:0] in_reg,
  input  logic [DATA_W-1:0] out_reg,
  input  logic [DATA_W-1:0] ctl_word,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      oe    <= 1'b0;
    end else begin
      oe <= ack | stb.rd_in | stb.rd_out | stb.rd_ctl;
      if (ack)             rdata <= VECTOR;
      else if (stb.rd_in)  rdata <= in_reg;
      else if (stb.rd_out) rdata <= out_reg;
      else if (stb.rd_ctl) rdata <= ctl_word;
      else                 rdata <= '0;
    end
  end

  assert_ack_vector_R4: assert property (@(posedge clk) disable iff (rst)
    ack |=> (oe && rdata == VECTOR));
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (rst)
    !(ack || stb.rd_in || stb.rd_out || stb.rd_ctl) |=> !oe);
endmodule

// File: rtl/vec_irq_periph.sv
module vec_irq_periph
  import vip_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h8000,
  parameter logic [DATA_W-1:0] VECTOR = 8'd16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              int_ack,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              int_req,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_oe,
  output logic [DATA_W-1:0] out_port
);
  vip_strobe_t stb;
  logic pending, mask, overrun;
  logic [DATA_W-1:0] in_reg, out_reg, ctl_word;

  vip_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .ack(int_ack), .stb(stb));

  vip_irq_ctl u_irq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rd_in(stb.rd_in),
    .wr_ctl(stb.wr_ctl), .wmask(bus_wdata[CTL_MASK_BIT]),
    .wovr_clr(bus_wdata[CTL_OVR_BIT]), .pending(pending), .mask(mask),
    .overrun(overrun), .int_req(int_req));

  vip_data_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .wr_out(stb.wr_out), .wdata(bus_wdata), .in_reg(in_reg), .out_reg(out_reg));

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_MASK_BIT] = mask;
    ctl_word[CTL_OVR_BIT]  = overrun;
    ctl_word[CTL_PEND_BIT] = pending;
  end

  vip_rd_drive #(.DATA_W(DATA_W), .VECTOR(VECTOR)) u_drv (
    .clk(clk), .rst(rst), .ack(int_ack), .stb(stb), .in_reg(in_reg),
    .out_reg(out_reg), .ctl_word(ctl_word), .rdata(bus_rdata), .oe(bus_oe));

  assign out_port = out_reg;

  assert_ack_keeps_req_R5: assert property (@(posedge clk) disable iff (rst)
    (int_ack && int_req && !in_valid && !stb.wr_ctl) |=> int_req);
endmodule

// File: tb/test_vec_irq_periph.sv
`timescale 1ns/1ps
module test_vec_irq_periph;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic bus_wr = 0, bus_rd = 0, int_ack = 0, in_valid = 0;
  logic [7:0] in_data = '0;
  logic int_req, bus_oe;
  logic [7:0] bus_rdata, out_port;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vec_irq_periph i_vec_irq_periph (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .int_ack(int_ack), .in_valid(in_valid),
    .in_data(in_data), .int_req(int_req), .bus_rdata(bus_rdata),
    .bus_oe(bus_oe), .out_port(out_port));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; int_ack = 0; in_valid = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    bus_addr = a; bus_rd = 1; tick();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick();
  endtask

  task automatic feed(input logic [7:0] d);
    in_data = d; in_valid = 1; tick();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 0;
    // R1 reset state
    chk("R1 int_req", int_req, 0);
    chk("R1 oe", bus_oe, 0);
    chk("R1 out_port", out_port, 0);
    rd(16'h8002);
    chk("R1 ctl", bus_rdata, 0);

    // R2/R3/R6 sweep of all byte values
    for (int d = 0; d < 256; d++) begin
      feed(d[7:0]);
      chk("R2 int_req", int_req, 1);
      rd(16'h8000);
      chk("R3 data", bus_rdata, d);
      chk("R3 oe", bus_oe, 1);
      chk("R3 cleared", int_req, 0);
      wr(16'h8001, 8'(255 - d));
      chk("R6 out_port", out_port, 255 - d);
      rd(16'h8001);
      chk("R6 readback", bus_rdata, 255 - d);
    end
    tick();
    chk("R11 idle oe", bus_oe, 0);

    // R4 acknowledge
    feed(8'h5A);
    int_ack = 1; tick();
    chk("R4 vector", bus_rdata, 16);
    chk("R4 oe", bus_oe, 1);
    chk("R4 req held", int_req, 1);
    // R5 ack with read
    int_ack = 1; bus_addr = 16'h8000; bus_rd = 1; tick();
    chk("R5 vector", bus_rdata, 16);
    chk("R5 req held", int_req, 1);
    rd(16'h8000);
    chk("R5 data intact", bus_rdata, 8'h5A);
    chk("R3 cleared after ack", int_req, 0);

    // R7 mask
    wr(16'h8002, 8'h01);
    feed(8'h33);
    chk("R7 masked", int_req, 0);
    rd(16'h8002);
    chk("R7 ctl mask+pend", bus_rdata, 5);
    wr(16'h8002, 8'h00);
    chk("R7 unmask", int_req, 1);
    rd(16'h8000);
    chk("R7 data", bus_rdata, 8'h33);

    // R8 overrun
    feed(8'h11);
    feed(8'h22);
    rd(16'h8002);
    chk("R8 ctl ovr+pend", bus_rdata, 6);
    rd(16'h8000);
    chk("R8 newest data", bus_rdata, 8'h22);
    rd(16'h8002);
    chk("R8 ovr sticky", bus_rdata, 2);
    wr(16'h8002, 8'h02);
    rd(16'h8002);
    chk("R8 ovr cleared", bus_rdata, 0);

    // R9 collision of new byte and read
    feed(8'h44);
    in_data = 8'h55; in_valid = 1; bus_addr = 16'h8000; bus_rd = 1; tick();
    chk("R9 old data", bus_rdata, 8'h44);
    chk("R9 still pending", int_req, 1);
    rd(16'h8002);
    chk("R9 no overrun", bus_rdata, 4);

    // R10 ignored accesses
    wr(16'h8003, 8'hFF);
    wr(16'h8000, 8'h77);
    rd(16'h8003);
    chk("R10 unmapped oe", bus_oe, 0);
    rd(16'h8000);
    chk("R10 in reg kept", bus_rdata, 8'h55);
    rd(16'h8001);
    chk("R10 out reg kept", bus_rdata, 0);
    chk("R10 out_port kept", out_port, 0);
    rd(16'h8002);
    chk("R10 ctl kept", bus_rdata, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule